// File: doc/BRIEF.md
# Interleaved Frame Buffer Scan Addresser

This block generates the sequence of video memory reads that scan out one field of a 320 by 240 picture made of 16-bit pixels. The picture is stored in vertical pairs. A 32-bit word holds the pixel of an even row in its upper half and the pixel directly beneath it in its lower half. Words follow one another along a row pair. After the last column of a pair, the next word starts the following pair. For every word the block issues a read on a memory port that answers in the same cycle. It then hands the word downstream on a valid/ready stream, split into an upper (left) and a lower (right) 16-bit channel, together with both pixel byte addresses and the scan position.

A field begins with a start pulse carrying the buffer pointer. Giving a different pointer on alternate fields gives double buffering. A display-list source may also post band pointers, each tagged with the even line where it takes effect. When the scan reaches that line, the following row pairs are fetched from the new pointer, counted from that line, until the next band takes over. Requests wait in a small ordered queue. A request that arrives after its line has already been scanned is dropped without effect. The last word of the field carries an end-of-field flag, and the block then stays idle until the next field start.

Top module: `fb_pair_scanner`

## Requirements
- R1: After reset, and until the first field start, out_valid and mem_en stay low.
- R2: A field_start pulse loads field_base with its two low bits forced to zero. It abandons any scan in progress and drops any undelivered output word, and the next word delivered is row 0, column 0 at that aligned base.
- R3: The word for column c of row pair k (rows 2k and 2k+1) is at byte address B + 4*((k-k0)*320 + c), where B is the current band or field base and k0 is the pair where that base took effect (0 for the field base). Words are delivered with columns 0 to 319 in order, then the next pair. out_addr_lower equals out_addr_upper + 2, out_col equals c and out_row equals 2k.
- R4: The memory answers mem_addr combinationally while mem_en is high. out_left is bits 31:16 and out_right is bits 15:0 of the word read at out_addr_upper.
- R5: With out_ready held high, one word is delivered per cycle with no gap. While out_valid is high and out_ready is low, all output fields hold their values.
- R6: out_eof is high only on the word for column 319, row 238. After that word, mem_en and out_valid stay low until the next field_start.
- R7: A band_wr with an even band_line L queues the pointer band_base (two low bits forced to zero). From row pair L/2 onward, words are addressed from it with k0 = L/2, until a later queued band takes effect. Queued bands take effect in the order they were written.
- R8: A band_wr whose band_line is odd is ignored and changes no address.
- R9: A queued band whose line is already being scanned or has been passed when it reaches the head of the queue is discarded with no effect. Bands queued behind it still take effect.
- R10: At most four band requests wait at once. A band_wr while four are waiting is ignored.
- R11: field_start discards all waiting band requests. A band_wr in the same cycle as field_start is kept for the new field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| field_start | input | 1 | Start-of-field pulse |
| field_base | input | 24 | Byte pointer of the buffer for the new field |
| band_wr | input | 1 | Band pointer request strobe |
| band_line | input | 8 | Line where the band takes effect (even only) |
| band_base | input | 24 | Byte pointer of the band |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | 24 | Byte address of the word being read |
| mem_rdata | input | 32 | Word returned by memory in the same cycle |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_addr_upper | output | 24 | Byte address of the even-row pixel |
| out_addr_lower | output | 24 | Byte address of the odd-row pixel |
| out_left | output | 16 | Upper 16 bits of the word (even row pixel) |
| out_right | output | 16 | Lower 16 bits of the word (odd row pixel) |
| out_col | output | 9 | Column of the word |
| out_row | output | 8 | Even row of the pair |
| out_eof | output | 1 | Last word of the field |

## Verification
A column or pair counter that slips shows on the very next delivered word as an address that is not the previous one plus four, or as a wrong out_col or out_row. A band queue that holds a discarded, overflowing or stale entry shows at the first word of the row pair where a band should start or should not start. There the address jumps to the wrong base, and the error persists for every later word of the field. A faulty output register shows within one stalled cycle as a changed, lost or repeated word. A missed restart shows on the first word after field_start as something other than column 0 at the new base.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

    localparam int FB_COLS           = 320;
    localparam int FB_ROWS           = 240;
    localparam int FB_PAIRS          = FB_ROWS / 2;
    localparam int FB_PTR_W          = 24;
    localparam int FB_PIX_W          = 16;
    localparam int FB_WORD_W         = 2 * FB_PIX_W;
    localparam int FB_BYTES_PER_WORD = FB_WORD_W / 8;
    localparam int FB_LOWER_OFS      = FB_PIX_W / 8;
    localparam int FB_COL_W          = $clog2(FB_COLS);
    localparam int FB_LINE_W         = $clog2(FB_ROWS);
    localparam int FB_PAIR_W         = $clog2(FB_PAIRS);

    typedef logic [FB_PTR_W-1:0]  fb_ptr_t;
    typedef logic [FB_WORD_W-1:0] fb_word_t;
    typedef logic [FB_PIX_W-1:0]  fb_pix_t;
    typedef logic [FB_COL_W-1:0]  fb_col_t;
    typedef logic [FB_PAIR_W-1:0] fb_pair_t;
    typedef logic [FB_LINE_W-1:0] fb_line_t;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_t;

    typedef struct packed {
        fb_line_t line;
        fb_ptr_t  base;
    } band_req_t;

    typedef struct packed {
        fb_ptr_t  addr;
        fb_col_t  col;
        fb_pair_t pair;
        logic     eof;
    } fetch_pos_t;

    typedef struct packed {
        fetch_pos_t pos;
        fb_pix_t    left;
        fb_pix_t    right;
    } out_word_t;

    function automatic fb_ptr_t word_align(input fb_ptr_t p);
        return p & ~fb_ptr_t'(FB_BYTES_PER_WORD - 1);
    endfunction

    function automatic fb_ptr_t next_word_addr(input fb_ptr_t p);
        return p + fb_ptr_t'(FB_BYTES_PER_WORD);
    endfunction

    function automatic fb_ptr_t lower_pixel_addr(input fb_ptr_t p);
        return p + fb_ptr_t'(FB_LOWER_OFS);
    endfunction

    function automatic fb_line_t pair_first_line(input fb_pair_t pr);
        return {pr, 1'b0};
    endfunction

    function automatic logic is_last_col(input fb_col_t c);
        return c == fb_col_t'(FB_COLS - 1);
    endfunction

    function automatic logic is_last_pair(input fb_pair_t pr);
        return pr == fb_pair_t'(FB_PAIRS - 1);
    endfunction

    function automatic fb_pix_t upper_lane(input fb_word_t w);
        return w[FB_WORD_W-1:FB_PIX_W];
    endfunction

    function automatic fb_pix_t lower_lane(input fb_word_t w);
        return w[FB_PIX_W-1:0];
    endfunction

endpackage

// File: rtl/fb_band_queue.sv
module fb_band_queue
    import fb_scan_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      push,
    input  band_req_t push_req,
    input  logic      pop,
    output logic      head_valid,
    output band_req_t head,
    output logic      full
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    band_req_t          slots [DEPTH];
    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic [CNT_W-1:0]   count;
    logic               do_push;
    logic               do_pop;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(DEPTH - 1)) ? '0 : i + IDX_W'(1);
    endfunction

    always_comb begin
        head_valid = count != '0;
        full       = count == CNT_W'(DEPTH);
        head       = slots[rd_idx];
        do_push    = push && !full;
        do_pop     = pop && head_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx <= '0;
            wr_idx <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_idx <= '0;
            wr_idx <= push ? IDX_W'(1 % DEPTH) : '0;
            count  <= push ? CNT_W'(1) : '0;
        end else begin
            if (do_push) begin
                wr_idx <= bump(wr_idx);
            end
            if (do_pop) begin
                rd_idx <= bump(rd_idx);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slots[s] <= '0;
                end else if (flush) begin
                    if (push && s == 0) begin
                        slots[s] <= push_req;
                    end
                end else if (do_push && wr_idx == IDX_W'(s)) begin
                    slots[s] <= push_req;
                end
            end
        end
    endgenerate

    AST_Q_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));  // R10

    AST_Q_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);  // R10

    AST_Q_EVEN_HEAD: assert property (@(posedge clk) disable iff (rst)
        head_valid |-> !head.line[0]);  // R8

    AST_Q_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (flush && !push) |=> !head_valid);  // R11

endmodule

// File: rtl/fb_scan_fetch.sv
module fb_scan_fetch
    import fb_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  fb_ptr_t    start_base,
    input  logic       advance,
    input  logic       head_valid,
    input  band_req_t  head,
    output logic       running,
    output logic       head_match,
    output logic       head_stale,
    output fetch_pos_t pos
);

    scan_state_t state;
    fb_col_t     col_q;
    fb_pair_t    pair_q;
    fb_ptr_t     addr_q;
    fb_line_t    cur_line;
    logic        pair_begun;

    always_comb begin
        cur_line   = pair_first_line(pair_q);
        pair_begun = col_q != '0;
        running    = state == SCAN_RUN;
        head_match = running && head_valid && !pair_begun && head.line == cur_line;
        head_stale = running && head_valid &&
                     ((head.line < cur_line) || (head.line == cur_line && pair_begun));
        pos.addr   = head_match ? word_align(head.base) : addr_q;
        pos.col    = col_q;
        pos.pair   = pair_q;
        pos.eof    = is_last_col(col_q) && is_last_pair(pair_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SCAN_IDLE;
            col_q  <= '0;
            pair_q <= '0;
            addr_q <= '0;
        end else if (start) begin
            state  <= SCAN_RUN;
            col_q  <= '0;
            pair_q <= '0;
            addr_q <= word_align(start_base);
        end else if (advance) begin
            addr_q <= next_word_addr(pos.addr);
            if (is_last_col(col_q)) begin
                col_q <= '0;
                if (is_last_pair(pair_q)) begin
                    state <= SCAN_IDLE;
                end else begin
                    pair_q <= pair_q + fb_pair_t'(1);
                end
            end else begin
                col_q <= col_q + fb_col_t'(1);
            end
        end
    end

    AST_ADV_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
        advance |-> running);  // R6

    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !start && !is_last_col(col_q))
            |=> (col_q == $past(col_q) + fb_col_t'(1)) && (pair_q == $past(pair_q)));  // R3

    AST_PAIR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (advance && !start && is_last_col(col_q) && !is_last_pair(pair_q))
            |=> (col_q == '0) && (pair_q == $past(pair_q) + fb_pair_t'(1)));  // R3

    AST_IDLE_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
        (advance && pos.eof && !start) |=> !running);  // R6

endmodule

// File: rtl/fb_out_stage.sv
module fb_out_stage
    import fb_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      load,
    input  out_word_t in_word,
    input  logic      ready,
    output logic      valid,
    output out_word_t word,
    output logic      can_load
);

    always_comb begin
        can_load = !valid || ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            word  <= '0;
        end else if (flush) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            word  <= in_word;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        load |-> can_load);  // R5

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !flush) |=> valid && $stable(word));  // R5

endmodule

// File: rtl/fb_pair_scanner.sv
module fb_pair_scanner
    import fb_scan_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 field_start,
    input  logic [FB_PTR_W-1:0]  field_base,
    input  logic                 band_wr,
    input  logic [FB_LINE_W-1:0] band_line,
    input  logic [FB_PTR_W-1:0]  band_base,
    output logic                 mem_en,
    output logic [FB_PTR_W-1:0]  mem_addr,
    input  logic [FB_WORD_W-1:0] mem_rdata,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [FB_PTR_W-1:0]  out_addr_upper,
    output logic [FB_PTR_W-1:0]  out_addr_lower,
    output logic [FB_PIX_W-1:0]  out_left,
    output logic [FB_PIX_W-1:0]  out_right,
    output logic [FB_COL_W-1:0]  out_col,
    output logic [FB_LINE_W-1:0] out_row,
    output logic                 out_eof
);

    band_req_t  new_req;
    band_req_t  head;
    logic       head_valid;
    logic       q_full;
    logic       q_push;
    logic       q_pop;
    logic       running;
    logic       head_match;
    logic       head_stale;
    logic       can_load;
    logic       fire;
    fetch_pos_t pos;
    out_word_t  fetched;
    out_word_t  held;

    always_comb begin
        new_req.line = band_line;
        new_req.base = band_base;
        q_push       = band_wr && !band_line[0];
        fire         = running && !head_stale && can_load && !field_start;
        q_pop        = head_stale || (head_match && fire);
        fetched.pos   = pos;
        fetched.left  = upper_lane(mem_rdata);
        fetched.right = lower_lane(mem_rdata);
        mem_en        = fire;
        mem_addr      = pos.addr;
    end

    fb_band_queue #(
        .DEPTH(QDEPTH)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (field_start),
        .push      (q_push),
        .push_req  (new_req),
        .pop       (q_pop),
        .head_valid(head_valid),
        .head      (head),
        .full      (q_full)
    );

    fb_scan_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (field_start),
        .start_base(field_base),
        .advance   (fire),
        .head_valid(head_valid),
        .head      (head),
        .running   (running),
        .head_match(head_match),
        .head_stale(head_stale),
        .pos       (pos)
    );

    fb_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .flush   (field_start),
        .load    (fire),
        .in_word (fetched),
        .ready   (out_ready),
        .valid   (out_valid),
        .word    (held),
        .can_load(can_load)
    );

    always_comb begin
        out_addr_upper = held.pos.addr;
        out_addr_lower = lower_pixel_addr(held.pos.addr);
        out_left       = held.left;
        out_right      = held.right;
        out_col        = held.pos.col;
        out_row        = pair_first_line(held.pos.pair);
        out_eof        = held.pos.eof;
    end

    AST_ADDR_CONSEC: assert property (@(posedge clk) disable iff (rst)
        (fire && pos.col != '0) |-> mem_addr == next_word_addr(held.pos.addr));  // R3

    AST_EOF_POSITION: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eof)
            |-> (out_col == FB_COL_W'(FB_COLS - 1)) && (out_row == FB_LINE_W'(FB_ROWS - 2)));  // R6

    AST_NO_OUT_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);  // R1

    AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (rst)
        field_start |=> !out_valid);  // R2

    AST_FULL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (q_full && !q_pop && !field_start) |=> head == $past(head));  // R10

endmodule

// File: tb/tb_fb_pair_scanner.sv
module tb_fb_pair_scanner;
    import fb_scan_pkg::*;

    localparam int NWORDS = FB_COLS * FB_PAIRS;

    logic        clk = 1'b0;
    logic        rst;
    logic        field_start;
    logic [23:0] field_base;
    logic        band_wr;
    logic [7:0]  band_line;
    logic [23:0] band_base;
    logic        mem_en;
    logic [23:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_addr_upper;
    logic [23:0] out_addr_lower;
    logic [15:0] out_left;
    logic [15:0] out_right;
    logic [8:0]  out_col;
    logic [7:0]  out_row;
    logic        out_eof;

    always #10 clk = ~clk;

    assign mem_rdata = {mem_addr[15:0] ^ 16'hA5C3, mem_addr[23:8] ^ 16'h0F0F};

    fb_pair_scanner dut (
        .clk(clk), .rst(rst), .field_start(field_start), .field_base(field_base),
        .band_wr(band_wr), .band_line(band_line), .band_base(band_base),
        .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr_upper(out_addr_upper), .out_addr_lower(out_addr_lower),
        .out_left(out_left), .out_right(out_right),
        .out_col(out_col), .out_row(out_row), .out_eof(out_eof)
    );

    int checks = 0;
    int errors = 0;

    int          n_wr;
    int          wr_at   [8];
    int          wr_line [8];
    logic [23:0] wr_base [8];
    bit          wr_done [8];
    int          n_eff;
    int          eff_line [8];
    logic [23:0] eff_base [8];
    logic [23:0] cur_fbase;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_addr(input int p, input int c);
        logic [23:0] b;
        int org;
        b = cur_fbase & 24'hFFFFFC;
        org = 0;
        for (int i = 0; i < n_eff; i++) begin
            if (eff_line[i] / 2 <= p) begin
                b = eff_base[i] & 24'hFFFFFC;
                org = eff_line[i] / 2;
            end
        end
        return b + 24'(4 * ((p - org) * FB_COLS + c));
    endfunction

    task automatic scan_field(input logic [23:0] base, input int rmode, input int stop_after,
                              input bit chk_rate, input string tag);
        int words, cyc, first_cyc, last_cyc, p, c;
        bit held, idle_ok;
        logic [23:0] h_addr, ea;
        logic [15:0] h_left;
        cur_fbase = base;
        for (int i = 0; i < 8; i++) wr_done[i] = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        field_start = 1'b1;
        field_base = base;
        band_wr = 1'b0;
        for (int i = 0; i < n_wr; i++) begin
            if (wr_at[i] < 0) begin
                band_wr = 1'b1; band_line = 8'(wr_line[i]); band_base = wr_base[i];
                wr_done[i] = 1'b1;
                break;
            end
        end
        @(negedge clk);
        field_start = 1'b0;
        band_wr = 1'b0;
        words = 0; cyc = 0; held = 1'b0; first_cyc = -1; last_cyc = 0;
        while (words < NWORDS && !(stop_after > 0 && words >= stop_after)) begin
            band_wr = 1'b0;
            for (int i = 0; i < n_wr; i++) begin
                if (!wr_done[i] && wr_at[i] <= words) begin
                    band_wr = 1'b1; band_line = 8'(wr_line[i]); band_base = wr_base[i];
                    wr_done[i] = 1'b1;
                    break;
                end
            end
            out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (held) begin
                check(out_valid && out_addr_upper == h_addr && out_left == h_left,
                      "R5", "word held under stall", out_addr_upper, h_addr);
                held = 1'b0;
            end
            if (out_valid) begin
                if (out_ready) begin
                    p = words / FB_COLS;
                    c = words % FB_COLS;
                    ea = exp_addr(p, c);
                    check(out_addr_upper == ea, tag, "upper address", out_addr_upper, ea);
                    check(out_addr_lower == ea + 24'd2, "R3", "lower address", out_addr_lower, ea + 24'd2);
                    check(out_col == 9'(c) && out_row == 8'(2 * p), "R3", "row/col",
                          {out_row, out_col}, {8'(2 * p), 9'(c)});
                    check(out_left == (ea[15:0] ^ 16'hA5C3) && out_right == (ea[23:8] ^ 16'h0F0F),
                          "R4", "left/right lanes", {out_left, out_right},
                          {ea[15:0] ^ 16'hA5C3, ea[23:8] ^ 16'h0F0F});
                    check(out_eof == (words == NWORDS - 1), "R6", "eof flag", out_eof, words == NWORDS - 1);
                    if (first_cyc < 0) first_cyc = cyc;
                    last_cyc = cyc;
                    words++;
                end else begin
                    held = 1'b1;
                    h_addr = out_addr_upper;
                    h_left = out_left;
                end
            end
            cyc++;
            @(negedge clk);
        end
        band_wr = 1'b0;
        if (stop_after > 0) begin
            out_ready = 1'b0;
        end else begin
            out_ready = 1'b1;
            idle_ok = 1'b1;
            for (int i = 0; i < 20; i++) begin
                if (out_valid || mem_en) idle_ok = 1'b0;
                @(negedge clk);
            end
            check(idle_ok, "R6", "idle after end of field", idle_ok, 1);
            if (chk_rate)
                check(last_cyc - first_cyc == NWORDS - 1, "R5", "one word per cycle",
                      last_cyc - first_cyc, NWORDS - 1);
        end
    endtask

    task automatic test_reset();
        bit quiet;
        rst = 1'b1; field_start = 1'b0; field_base = '0; band_wr = 1'b0;
        band_line = '0; band_base = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (out_valid || mem_en) quiet = 1'b0;
        end
        check(quiet, "R1", "no activity before first field", quiet, 1);
    endtask

    task automatic test_plain_field();
        n_wr = 0; n_eff = 0;
        scan_field(24'h001000, 0, 0, 1'b1, "R3");
    endtask

    task automatic test_banded_backpressure();
        n_wr = 6;
        wr_at[0] = -1; wr_line[0] = 40;  wr_base[0] = 24'h200000;
        wr_at[1] = 0;  wr_line[1] = 61;  wr_base[1] = 24'h600000;
        wr_at[2] = 1;  wr_line[2] = 100; wr_base[2] = 24'h300002;
        wr_at[3] = 2;  wr_line[3] = 150; wr_base[3] = 24'h340000;
        wr_at[4] = 3;  wr_line[4] = 170; wr_base[4] = 24'h380000;
        wr_at[5] = 4;  wr_line[5] = 190; wr_base[5] = 24'h3C0000;
        n_eff = 4;
        eff_line[0] = 40;  eff_base[0] = 24'h200000;
        eff_line[1] = 100; eff_base[1] = 24'h300002;
        eff_line[2] = 150; eff_base[2] = 24'h340000;
        eff_line[3] = 170; eff_base[3] = 24'h380000;
        scan_field(24'h080000, 1, 0, 1'b0, "R7 R8 R10 R11");
    endtask

    task automatic test_restart_partial();
        n_wr = 1;
        wr_at[0] = -1; wr_line[0] = 200; wr_base[0] = 24'h500000;
        n_eff = 1;
        eff_line[0] = 200; eff_base[0] = 24'h500000;
        scan_field(24'h100000, 0, 1000, 1'b0, "R2");
    endtask

    task automatic test_stale_after_restart();
        n_wr = 2;
        wr_at[0] = 2000; wr_line[0] = 4;   wr_base[0] = 24'h700000;
        wr_at[1] = 2001; wr_line[1] = 160; wr_base[1] = 24'h600000;
        n_eff = 1;
        eff_line[0] = 160; eff_base[0] = 24'h600000;
        scan_field(24'h140003, 0, 0, 1'b0, "R2 R9 R11");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset();
        test_plain_field();
        test_banded_backpressure();
        test_restart_partial();
        test_stale_after_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule